// File: doc/BRIEF.md
# Peripheral Enable Address Router

This block holds an eleven-bit enable register, one enable per on-chip extension target (two CAN controllers, two RAM blocks, a real-time clock, a flash control window, a PWM unit, an asynchronous serial port, a synchronous serial port, an I2C unit and a miscellaneous unit). For every internal bus access it decides where the access goes. The possible destinations are one of the on-chip targets, external memory, or nowhere, in which case a bus error is flagged.

The two RAM blocks and the flash control window each own a private window. When a private window's enable is clear, its addresses pass to external memory. The eight peripherals share one group region and follow a stricter rule. Accesses into that region fall through to external memory only while all eight of them are disabled. If any one of them is enabled, an access to a disabled member selects nothing and raises a bus error. Addresses that no window claims always go to external memory.

The outputs are combinational in the address and the access strobe. They are computed against the registered enables, so a register write steers accesses from the following clock cycle onwards.

Top module: `periph_route_top`

## Requirements
- R1: After reset the enable register holds 005h: only CAN1 (bit 0) and RAM1 (bit 2) are enabled.
- R2: A write through `cfg_wr`/`cfg_wdata` updates the enables at the next rising clock edge. An access in the same cycle as the write still sees the old enables. Data bits 15:11 are discarded.
- R3: RAM1 (bit 2) spans 00E000h–00E7FFh. An access there asserts `sel_tgt[2]` when bit 2 is set, and otherwise asserts `sel_ext`.
- R4: RAM2 (bit 3, 00C000h–00DFFFh) and the flash control window (bit 5, 00F000h–00F0FFh) follow the same rule as RAM1, each with its own bit.
- R5: The group peripherals decode these sub-ranges: CAN1 bit 0 EC00h–EDFFh, CAN2 bit 1 EE00h–EFFFh, RTC bit 4 E800h–E87Fh, PWM bit 6 E880h–E8FFh, ASC bit 7 E900h–E97Fh, SSC bit 8 E980h–E9FFh, I2C bit 9 EA00h–EA7Fh, MISC bit 10 EA80h–EAFFh (upper address bits zero). An access to an enabled one asserts `sel_tgt[bit]`.
- R6: An access to any group sub-range asserts `sel_ext` only while all eight group enables (bits 0,1,4,6,7,8,9,10) are clear.
- R7: An access to a disabled group peripheral while another group enable is set asserts no select and raises `bus_err`.
- R8: Addresses outside every window assert `sel_ext`. This includes the unclaimed span 00EB00h–00EBFFh and any address with a nonzero bit above bit 15.
- R9: With `bus_req` low, `sel_tgt`, `sel_ext` and `bus_err` are all 0.
- R10: During an access exactly one of the outputs `sel_tgt` bits, `sel_ext` and `bus_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_wdata | input | 16 | Enable register write data |
| bus_addr | input | ADDR_W (24) | Internal bus byte address |
| bus_req | input | 1 | Access strobe |
| sel_tgt | output | 11 | One-hot on-chip target select, indexed by enable bit |
| sel_ext | output | 1 | External memory select |
| bus_err | output | 1 | Access to a blocked group peripheral |

## Verification
The bench builds the router with its default parameters: a 24-bit address, a 16-bit register and a reset value of 005h. The 24-bit address lets the bench reach aliases above 64 Kbytes, such as 01EC00h and FFFFFFh, and confirm that the upper bits take part in decoding. The reset value puts the group in its mixed state straight out of reset, so a CAN2 access can be checked for a bus error before any write. Later writes drive the group through all-off, single-member and all-on states, and the bench probes the first and last byte of every window.

// File: rtl/periph_route_pkg.sv
package periph_route_pkg;

  localparam int NUM_TGT = 11;

  // enable bit positions (register layout)
  localparam int B_CAN1  = 0;
  localparam int B_CAN2  = 1;
  localparam int B_RAM1  = 2;
  localparam int B_RAM2  = 3;
  localparam int B_RTC   = 4;
  localparam int B_FLASH = 5;
  localparam int B_PWM   = 6;
  localparam int B_ASC   = 7;
  localparam int B_SSC   = 8;
  localparam int B_I2C   = 9;
  localparam int B_MISC  = 10;

  // members of the shared peripheral group
  localparam logic [NUM_TGT-1:0] GROUP_MASK =
    (NUM_TGT'(1) << B_CAN1) | (NUM_TGT'(1) << B_CAN2) | (NUM_TGT'(1) << B_RTC) |
    (NUM_TGT'(1) << B_PWM)  | (NUM_TGT'(1) << B_ASC)  | (NUM_TGT'(1) << B_SSC) |
    (NUM_TGT'(1) << B_I2C)  | (NUM_TGT'(1) << B_MISC);

  // window base address of a target
  function automatic logic [31:0] tgt_base(input int idx);
    case (idx)
      B_CAN1:  return 32'h0000_EC00;
      B_CAN2:  return 32'h0000_EE00;
      B_RAM1:  return 32'h0000_E000;
      B_RAM2:  return 32'h0000_C000;
      B_RTC:   return 32'h0000_E800;
      B_FLASH: return 32'h0000_F000;
      B_PWM:   return 32'h0000_E880;
      B_ASC:   return 32'h0000_E900;
      B_SSC:   return 32'h0000_E980;
      B_I2C:   return 32'h0000_EA00;
      default: return 32'h0000_EA80;
    endcase
  endfunction

  // window size as a power of two (bytes)
  function automatic int tgt_span_log2(input int idx);
    case (idx)
      B_CAN1, B_CAN2: return 9;
      B_RAM1:         return 11;
      B_RAM2:         return 13;
      B_FLASH:        return 8;
      default:        return 7;
    endcase
  endfunction

  // address falls inside the aligned window of a target
  function automatic logic in_window(input logic [31:0] addr, input int idx);
    int sh;
    sh = tgt_span_log2(idx);
    return (addr >> sh) == (tgt_base(idx) >> sh);
  endfunction

endpackage

// File: rtl/periph_en_reg.sv
module periph_en_reg #(
  parameter int                REG_W   = 16,
  parameter int                NUM_EN  = 11,
  parameter logic [REG_W-1:0]  RST_VAL = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NUM_EN-1:0] en_q
);

  localparam logic [NUM_EN-1:0] RST_EN = RST_VAL[NUM_EN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= RST_EN;
    end else if (wr_en) begin
      en_q <= wr_data[NUM_EN-1:0];
    end
  end

  // bits above NUM_EN are not stored
  logic unused_hi;
  assign unused_hi = ^wr_data[REG_W-1:NUM_EN];

endmodule

// File: rtl/periph_win_decode.sv
module periph_win_decode
  import periph_route_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_EN = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_EN-1:0] hit
);

  logic [31:0] addr_x;
  assign addr_x = 32'(addr);

  for (genvar g = 0; g < NUM_EN; g++) begin : g_win
    assign hit[g] = in_window(addr_x, g);
  end

endmodule

// File: rtl/periph_route_resolve.sv
module periph_route_resolve #(
  parameter int                 NUM_EN = 11,
  parameter logic [NUM_EN-1:0]  GRP    = '0
) (
  input  logic              req,
  input  logic [NUM_EN-1:0] hit,
  input  logic [NUM_EN-1:0] en_q,
  output logic [NUM_EN-1:0] sel_tgt,
  output logic              sel_ext,
  output logic              bus_err,
  output logic              grp_hit,
  output logic              grp_any_en
);

  logic [NUM_EN-1:0] live_hit;
  logic              any_hit;
  logic              solo_dark;
  logic              grp_dark;
  logic              grp_block;

  always_comb begin
    live_hit   = hit & en_q;
    any_hit    = |hit;
    grp_hit    = |(hit & GRP);
    grp_any_en = |(en_q & GRP);
    solo_dark  = |(hit & ~en_q & ~GRP);
    grp_dark   = grp_hit && !grp_any_en;
    grp_block  = grp_hit && grp_any_en && !(|live_hit);

    sel_tgt = req ? live_hit : '0;
    sel_ext = req && (!any_hit || solo_dark || grp_dark);
    bus_err = req && grp_block;
  end

endmodule

// File: rtl/periph_route_top.sv
module periph_route_top
  import periph_route_pkg::*;
#(
  parameter int               ADDR_W  = 24,
  parameter int               REG_W   = 16,
  parameter logic [REG_W-1:0] RST_VAL = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_req,
  output logic [NUM_TGT-1:0] sel_tgt,
  output logic              sel_ext,
  output logic              bus_err
);

  logic [NUM_TGT-1:0] en_q;
  logic [NUM_TGT-1:0] win_hit;
  logic               grp_hit;
  logic               grp_any_en;

  periph_en_reg #(
    .REG_W  (REG_W),
    .NUM_EN (NUM_TGT),
    .RST_VAL(RST_VAL)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_data(cfg_wdata),
    .en_q   (en_q)
  );

  periph_win_decode #(
    .ADDR_W(ADDR_W),
    .NUM_EN(NUM_TGT)
  ) u_dec (
    .addr(bus_addr),
    .hit (win_hit)
  );

  periph_route_resolve #(
    .NUM_EN(NUM_TGT),
    .GRP   (GROUP_MASK)
  ) u_res (
    .req       (bus_req),
    .hit       (win_hit),
    .en_q      (en_q),
    .sel_tgt   (sel_tgt),
    .sel_ext   (sel_ext),
    .bus_err   (bus_err),
    .grp_hit   (grp_hit),
    .grp_any_en(grp_any_en)
  );

endmodule

// File: rtl/periph_route_chk.sv
module periph_route_chk #(
  parameter int               REG_W   = 16,
  parameter int               NUM_EN  = 11,
  parameter logic [REG_W-1:0] RST_VAL = 16'h0005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic              bus_req,
  input logic [NUM_EN-1:0] sel_tgt,
  input logic              sel_ext,
  input logic              bus_err,
  input logic [NUM_EN-1:0] en_q,
  input logic              grp_hit,
  input logic              grp_any_en
);

  AST_RESET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en_q == RST_VAL[NUM_EN-1:0]);  // R1

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> en_q == $past(cfg_wdata[NUM_EN-1:0]));  // R2

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(en_q));  // R2

  AST_SEL_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tgt & ~en_q) == '0);  // R5

  AST_GROUP_NO_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && grp_hit && grp_any_en) |-> !sel_ext);  // R6

  AST_ERR_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (grp_hit && grp_any_en));  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (sel_tgt == '0 && !sel_ext && !bus_err));  // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $countones({sel_tgt, sel_ext, bus_err}) == 1);  // R10

endmodule

bind periph_route_top periph_route_chk #(
  .REG_W  (REG_W),
  .NUM_EN (periph_route_pkg::NUM_TGT),
  .RST_VAL(RST_VAL)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .bus_req   (bus_req),
  .sel_tgt   (sel_tgt),
  .sel_ext   (sel_ext),
  .bus_err   (bus_err),
  .en_q      (en_q),
  .grp_hit   (grp_hit),
  .grp_any_en(grp_any_en)
);

// File: tb/periph_route_top_tb_top.sv
module periph_route_top_tb_top;

  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [AW-1:0] bus_addr = '0;
  logic        bus_req = 1'b0;
  logic [10:0] sel_tgt;
  logic        sel_ext;
  logic        bus_err;

  int n_chk = 0;
  int n_err = 0;
  logic [10:0] shadow;  // bench's own view of the enables

  always #10 clk = ~clk;  // 50 MHz

  periph_route_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_req(bus_req),
    .sel_tgt(sel_tgt), .sel_ext(sel_ext), .bus_err(bus_err)
  );

  // window bounds per enable bit, restated from the requirements
  function automatic logic [23:0] lo_of(input int b);
    logic [23:0] t [11] = '{24'h00EC00, 24'h00EE00, 24'h00E000, 24'h00C000,
                             24'h00E800, 24'h00F000, 24'h00E880, 24'h00E900,
                             24'h00E980, 24'h00EA00, 24'h00EA80};
    return t[b];
  endfunction
  function automatic logic [23:0] hi_of(input int b);
    logic [23:0] t [11] = '{24'h00EDFF, 24'h00EFFF, 24'h00E7FF, 24'h00DFFF,
                             24'h00E87F, 24'h00F0FF, 24'h00E8FF, 24'h00E97F,
                             24'h00E9FF, 24'h00EA7F, 24'h00EAFF};
    return t[b];
  endfunction
  function automatic logic is_grp(input int b);
    return !(b == 2 || b == 3 || b == 5);
  endfunction

  // expected {bus_err, sel_ext, sel_tgt}
  function automatic logic [12:0] model(input logic [23:0] a, input logic [10:0] en,
                                        input logic req);
    int   hit_b;
    logic grp_on;
    hit_b  = -1;
    grp_on = 1'b0;
    for (int b = 0; b < 11; b++) begin
      if (a >= lo_of(b) && a <= hi_of(b)) hit_b = b;
      if (is_grp(b) && en[b]) grp_on = 1'b1;
    end
    if (!req) return '0;
    if (hit_b < 0) return {2'b01, 11'd0};
    if (en[hit_b]) return {2'b00, 11'(11'd1 << hit_b)};
    if (is_grp(hit_b) && grp_on) return {2'b10, 11'd0};
    return {2'b01, 11'd0};
  endfunction

  task automatic check(input string req_tag, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got err/ext/sel=%b expected %b", req_tag, got, exp);
    end
  endtask

  task automatic probe(input string req_tag, input logic [23:0] a, input logic req);
    @(negedge clk);
    bus_addr = a;
    bus_req  = req;
    #3;
    check(req_tag, {bus_err, sel_ext, sel_tgt}, model(a, shadow, req));
  endtask

  task automatic write_en(input logic [15:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
    shadow    = v[10:0];
  endtask

  task automatic t_reset;
    shadow = 11'h005;
    probe("R1", 24'h00EC00, 1'b1);
    #1 check("R1", {bus_err, sel_ext, sel_tgt}, {2'b00, 11'h001});
    probe("R1", 24'h00E000, 1'b1);
    probe("R1", 24'h00EE00, 1'b1);  // CAN2 off, CAN1 on: error
    #1 check("R7", {bus_err, sel_ext, sel_tgt}, {2'b10, 11'h000});
    probe("R1", 24'h00C000, 1'b1);  // RAM2 off
  endtask

  task automatic t_idle;
    probe("R9", 24'h00EC00, 1'b0);
    probe("R9", 24'h00EE00, 1'b0);
    probe("R9", 24'h123456, 1'b0);
  endtask

  task automatic t_private;
    write_en(16'h0000);
    probe("R3", 24'h00E000, 1'b1);
    probe("R3", 24'h00E7FF, 1'b1);
    write_en(16'h002C);  // RAM1, RAM2, FLASH on; group dark
    probe("R3", 24'h00E7FF, 1'b1);
    probe("R4", 24'h00C000, 1'b1);
    probe("R4", 24'h00DFFF, 1'b1);
    probe("R4", 24'h00F0FF, 1'b1);
    probe("R4", 24'h00F100, 1'b1);
    probe("R6", 24'h00EC00, 1'b1);
    #1 check("R6", {bus_err, sel_ext, sel_tgt}, {2'b01, 11'h000});
    probe("R6", 24'h00EA80, 1'b1);
    probe("R6", 24'h00E800, 1'b1);
  endtask

  task automatic t_group_single;
    write_en(16'h0400);  // MISC only
    probe("R5", 24'h00EAFF, 1'b1);
    probe("R7", 24'h00EC00, 1'b1);
    probe("R7", 24'h00E9FF, 1'b1);
    #1 check("R7", {bus_err, sel_ext, sel_tgt}, {2'b10, 11'h000});
    probe("R3", 24'h00E400, 1'b1);  // RAM1 off -> external
  endtask

  task automatic t_all_on;
    write_en(16'h07FF);
    for (int b = 0; b < 11; b++) begin
      probe("R5", lo_of(b), 1'b1);
      probe("R5", hi_of(b), 1'b1);
    end
  endtask

  task automatic t_outside;
    probe("R8", 24'h00EB00, 1'b1);
    probe("R8", 24'h00EBFF, 1'b1);
    probe("R8", 24'h01EC00, 1'b1);
    probe("R8", 24'hFFFFFF, 1'b1);
    #1 check("R8", {bus_err, sel_ext, sel_tgt}, {2'b01, 11'h000});
    probe("R8", 24'h000000, 1'b1);
    probe("R8", 24'h00BFFF, 1'b1);
  endtask

  task automatic t_write_timing;
    // same-cycle access sees old enables, next cycle the new ones
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = 16'hF801;  // high bits discarded: CAN1 only
    bus_addr  = 24'h00E000;
    bus_req   = 1'b1;
    #3 check("R2", {bus_err, sel_ext, sel_tgt}, {2'b00, 11'h004});
    @(negedge clk);
    cfg_wr = 1'b0;
    #3 check("R2", {bus_err, sel_ext, sel_tgt}, {2'b01, 11'h000});
    shadow = 11'h001;
    probe("R2", 24'h00EC00, 1'b1);
    probe("R2", 24'h00EA00, 1'b1);
    probe("R2", 24'h00F000, 1'b1);
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_idle();
    t_private();
    t_group_single();
    t_all_on();
    t_outside();
    t_write_timing();
    @(negedge clk) bus_req = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule